// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Overrun Guard

This block takes in 8-bit bytes from a two-wire synchronous link made of a clock line and a data line. Each byte arrives least significant bit first, one bit per rising clock edge. In master mode the block drives the link clock itself from a power-of-two divider of the system clock, and keeps clocking for as long as it is enabled. Back-to-back bytes therefore flow without software starting each one. In slave mode the clock comes in from the line. It passes through a synchronizer, and its rising edges are found in the system-clock domain.

Every completed byte moves into a holding register and raises a receive-full flag, which a read of the holding register clears. If a byte completes while the flag is still set, the new byte is dropped, the held byte is kept, and a sticky overrun flag is raised. A stop request lets the byte in progress finish and then parks the master clock high. Software reaches all of this through a small register interface with three addresses.

Top module: `csrx_top`

## Requirements
- R1: After reset, both status flags read 0, the holding register reads 0x00, `scl_o` is 1 and `scl_oe` is 0.
- R2: With control bit 0 (enable) and bit 1 (master) set, `scl_oe` is 1 and `scl_o` toggles. Each bit period lasts 2^(n+1) system clocks, where n is control bits 7:4. The low half comes first, and the line sits high when idle.
- R3: The first received bit lands in bit 0 of the byte, and the eighth lands in bit 7.
- R4: In master mode, consecutive bytes are clocked in without a pause as long as software reads each one.
- R5: The receive-full flag (status bit 0 at address 1) is set only when a byte completes. A read with `rd_en` at address 2 returns the held byte and clears the flag.
- R6: A byte that completes while receive-full is still set raises overrun (status bit 1) and leaves the held byte unchanged.
- R7: Overrun stays set across reads and disable. Writing address 1 with bit 1 = 0 clears it, and writing bit 1 = 1 leaves it set.
- R8: With control bit 2 (stop) set during a master receive, the current byte completes, after which `scl_o` stays high and no further byte arrives.
- R9: With master = 0 and enable = 1, `scl_oe` is 0 and bytes are clocked in from the rising edges of `scl_i`.
- R10: Clearing enable discards a partly received byte, so the next byte after re-enabling is assembled from its own first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect at address 2) |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| scl_i | input | 1 | Link clock input (slave mode) |
| scl_o | output | 1 | Link clock output value (master mode) |
| scl_oe | output | 1 | Link clock output enable |
| sda_i | input | 1 | Link data input |

## Verification
The hardest states to reach are the ones tied to where a byte boundary falls against software activity. Examples are a second byte finishing while the first is unread, or a stop request landing in the middle of a byte. To get there, the bench runs a background data feeder that presents the next bit on every falling edge of the master clock. The main thread meanwhile polls status, withholds reads to provoke overrun, and writes the stop bit right after a byte has been consumed, so that it arrives part way through the next byte. Partial-byte discard is reached by driving only three slave clocks before disabling.

// File: rtl/csrx_pkg.sv
package csrx_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_MASTER_BIT = 1;
    localparam int CTRL_STOP_BIT   = 2;
    localparam int CTRL_SEL_LSB    = 4;

    localparam int STAT_FULL_BIT = 0;
    localparam int STAT_OVR_BIT  = 1;

    typedef struct packed {
        logic [3:0] clksel;
        logic       stop;
        logic       master;
        logic       enable;
    } ctrl_t;

endpackage

// File: rtl/csrx_clkgen.sv
module csrx_clkgen #(
    parameter int SEL_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] clksel_i,
    output logic             scl_o,
    output logic             rise_o
);

    typedef struct packed {
        logic             scl;
        logic             rise;
        logic [CNT_W-1:0] cnt;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic [CNT_W-1:0] half_m1;
    logic             phase_end;

    always_comb begin
        half_m1   = (CNT_W'(1) << clksel_i) - CNT_W'(1);
        phase_end = (st_q.cnt == half_m1);
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (!run_i) begin
            st_d.scl = 1'b1;
            st_d.cnt = '0;
        end else if (phase_end) begin
            st_d.cnt  = '0;
            st_d.scl  = ~st_q.scl;
            st_d.rise = ~st_q.scl;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl: 1'b1, rise: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o  = st_q.scl;
    assign rise_o = st_q.rise;

    // R2: the line never drops low while the generator is stopped
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> st_q.scl);

endmodule

// File: rtl/csrx_sync.sv
module csrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic rise_o,
    output logic sda_o
);

    typedef struct packed {
        logic [STAGES:0]   scl;
        logic [STAGES-1:0] sda;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.scl[0] = scl_i;
        st_d.sda[0] = sda_i;
        for (int i = 1; i <= STAGES; i++) begin
            st_d.scl[i] = st_q.scl[i-1];
        end
        for (int i = 1; i < STAGES; i++) begin
            st_d.sda[i] = st_q.sda[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl: '1, sda: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.scl[STAGES-1] & ~st_q.scl[STAGES];
    assign sda_o  = st_q.sda[STAGES-1];

endmodule

// File: rtl/csrx_shifter.sv
module csrx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         rise_i,
    input  logic         bit_i,
    output logic         done_o,
    output logic [W-1:0] byte_o
);

    localparam int CNT_W = $clog2(W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sh;
    } shf_st_t;

    shf_st_t st_d, st_q;

    assign done_o = en_i & rise_i & (st_q.cnt == CNT_W'(W-1));
    assign byte_o = {bit_i, st_q.sh[W-1:1]};

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (rise_i) begin
            st_d.sh  = {bit_i, st_q.sh[W-1:1]};
            st_d.cnt = done_o ? '0 : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: disabling wipes the bit position
    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/csrx_top.sv
module csrx_top
    import csrx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              scl_i,
    output logic              scl_o,
    output logic              scl_oe,
    input  logic              sda_i
);

    localparam int SEL_W = 4;
    localparam int CNT_W = 1 << SEL_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              full;
        logic              ovr;
        logic              parked;
        logic [DATA_W-1:0] data;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              gen_rise, gen_scl, run;
    logic              sync_rise, sync_sda;
    logic              shf_rise, shf_bit, byte_done;
    logic [DATA_W-1:0] byte_val;
    logic              data_rd;

    csrx_clkgen #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .clksel_i (st_q.ctrl.clksel),
        .scl_o    (gen_scl),
        .rise_o   (gen_rise)
    );

    csrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .rise_o (sync_rise),
        .sda_o  (sync_sda)
    );

    assign shf_rise = st_q.ctrl.master ? gen_rise : sync_rise;
    assign shf_bit  = st_q.ctrl.master ? sda_i    : sync_sda;

    csrx_shifter #(.W(DATA_W)) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.ctrl.enable),
        .rise_i (shf_rise),
        .bit_i  (shf_bit),
        .done_o (byte_done),
        .byte_o (byte_val)
    );

    assign data_rd = rd_en && (addr == ADDR_DATA);
    assign run     = st_q.ctrl.enable && st_q.ctrl.master && !st_q.parked
                     && !(byte_done && st_q.ctrl.stop);

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == ADDR_CTRL) begin
            st_d.ctrl.enable = wdata[CTRL_EN_BIT];
            st_d.ctrl.master = wdata[CTRL_MASTER_BIT];
            st_d.ctrl.stop   = wdata[CTRL_STOP_BIT];
            st_d.ctrl.clksel = wdata[CTRL_SEL_LSB +: SEL_W];
        end
        if (wr_en && addr == ADDR_STAT && !wdata[STAT_OVR_BIT]) begin
            st_d.ovr = 1'b0;
        end
        if (data_rd) begin
            st_d.full = 1'b0;
        end
        if (byte_done) begin
            if (st_q.full && !data_rd) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.data = byte_val;
                st_d.full = 1'b1;
            end
            if (st_q.ctrl.master && st_q.ctrl.stop) begin
                st_d.parked = 1'b1;
            end
        end
        if (!st_d.ctrl.enable || !st_d.ctrl.stop) begin
            st_d.parked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[CTRL_EN_BIT]              = st_q.ctrl.enable;
                rdata[CTRL_MASTER_BIT]          = st_q.ctrl.master;
                rdata[CTRL_STOP_BIT]            = st_q.ctrl.stop;
                rdata[CTRL_SEL_LSB +: SEL_W]    = st_q.ctrl.clksel;
            end
            ADDR_STAT: begin
                rdata[STAT_FULL_BIT] = st_q.full;
                rdata[STAT_OVR_BIT]  = st_q.ovr;
            end
            ADDR_DATA: rdata = st_q.data;
            default:   rdata = '0;
        endcase
    end

    assign scl_o  = gen_scl;
    assign scl_oe = st_q.ctrl.enable & st_q.ctrl.master;

    // R6: a dropped byte leaves the held byte alone and flags overrun
    assert_ovr_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st_q.full && !data_rd) |=> ($stable(st_q.data) && st_q.ovr));

    // R5: receive-full only rises on a completed byte
    assert_full_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |-> $past(byte_done));

    // R5: a data read with no byte completing empties the register
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !byte_done) |=> !st_q.full);

    // R8: once parked, the clock output is held high
    assert_parked_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.parked |-> gen_scl);

endmodule

// File: tb/csrx_top_bench.sv
`timescale 1ns/1ps
module csrx_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       scl_s = 1'b1;
    logic       scl_o, scl_oe;
    logic       sda_m = 1'b1, sda_s = 1'b1, use_slave = 1'b0;
    logic       sda_i;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] feed_mem [0:7];
    int feed_pos = 0;
    int feed_base = 0;

    assign sda_i = use_slave ? sda_s : sda_m;

    always #4 clk = ~clk;

    csrx_top u_csrx_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .scl_i(scl_s), .scl_o(scl_o),
        .scl_oe(scl_oe), .sda_i(sda_i)
    );

    always @(negedge scl_o) begin
        int idx;
        idx = feed_pos - feed_base;
        sda_m = feed_mem[(idx >> 3) % 8][idx % 8];
        feed_pos = feed_pos + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = (a == 2'd2);
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_stat(input int bitpos, output bit seen);
        seen = 1'b0;
        addr = 2'd1;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            addr = 2'd1;
            #1 if (rdata[bitpos]) seen = 1'b1;
        end
    endtask

    task automatic slave_bit(input logic b);
        scl_s = 1'b0; sda_s = b;
        repeat (4) @(negedge clk);
        scl_s = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset;
        logic [7:0] d;
        reg_rd(2'd1, d);
        check(d[1:0] == 2'b00, "R1 status", d, 0);
        reg_rd(2'd2, d);
        check(d == 8'h00, "R1 data", d, 0);
        check(scl_o == 1'b1, "R1 scl_o", scl_o, 1);
        check(scl_oe == 1'b0, "R1 scl_oe", scl_oe, 0);
    endtask

    task automatic test_clock;
        int lo, hi;
        feed_base = feed_pos;
        reg_wr(2'd0, 8'h13);
        check(scl_oe == 1'b1, "R2 oe", scl_oe, 1);
        do @(negedge clk); while (scl_o != 1'b0);
        lo = 0;
        do begin @(negedge clk); lo++; end while (scl_o == 1'b0);
        hi = 0;
        do begin @(negedge clk); hi++; end while (scl_o == 1'b1);
        check(lo == 2, "R2 low half", lo, 2);
        check(hi == 2, "R2 high half", hi, 2);
        reg_wr(2'd0, 8'h00);
        repeat (4) @(negedge clk);
        check(scl_o == 1'b1, "R2 idle high", scl_o, 1);
    endtask

    task automatic test_continuous_stop;
        logic [7:0] d;
        bit seen;
        int lows;
        feed_mem[0] = 8'hA5; feed_mem[1] = 8'h3C; feed_mem[2] = 8'h81;
        feed_base = feed_pos;
        reg_wr(2'd0, 8'h23);
        wait_stat(0, seen);
        reg_rd(2'd2, d);
        check(seen && d == 8'hA5, "R3 first byte LSB first", d, 8'hA5);
        reg_rd(2'd1, d);
        check(d[0] == 1'b0, "R5 read clears full", d[0], 0);
        wait_stat(0, seen);
        reg_rd(2'd2, d);
        check(seen && d == 8'h3C, "R4 second byte back to back", d, 8'h3C);
        reg_wr(2'd0, 8'h27);
        wait_stat(0, seen);
        reg_rd(2'd2, d);
        check(seen && d == 8'h81, "R8 byte in progress completes", d, 8'h81);
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (scl_o == 1'b0) lows++;
        end
        check(lows == 0, "R8 clock parked high", lows, 0);
        reg_rd(2'd1, d);
        check(d[1:0] == 2'b00, "R8 no further byte", d, 0);
        reg_wr(2'd0, 8'h00);
    endtask

    task automatic test_overrun;
        logic [7:0] d;
        bit seen;
        feed_mem[0] = 8'h11; feed_mem[1] = 8'h22; feed_mem[2] = 8'h33;
        feed_base = feed_pos;
        reg_wr(2'd0, 8'h13);
        wait_stat(0, seen);
        wait_stat(1, seen);
        check(seen, "R6 overrun raised", seen, 1);
        reg_rd(2'd2, d);
        check(d == 8'h11, "R6 old byte kept", d, 8'h11);
        reg_wr(2'd0, 8'h00);
        reg_rd(2'd1, d);
        check(d[1] == 1'b1, "R7 overrun sticky after read and disable", d[1], 1);
        reg_wr(2'd1, 8'h02);
        reg_rd(2'd1, d);
        check(d[1] == 1'b1, "R7 write 1 keeps overrun", d[1], 1);
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd1, d);
        check(d[1] == 1'b0, "R7 write 0 clears overrun", d[1], 0);
        reg_rd(2'd2, d);
    endtask

    task automatic test_slave;
        logic [7:0] d;
        bit seen;
        use_slave = 1'b1;
        reg_wr(2'd0, 8'h01);
        check(scl_oe == 1'b0, "R9 clock not driven", scl_oe, 0);
        for (int i = 0; i < 8; i++) slave_bit(d_bit(8'h96, i));
        wait_stat(0, seen);
        reg_rd(2'd2, d);
        check(seen && d == 8'h96, "R9 slave byte", d, 8'h96);
        slave_bit(1'b1); slave_bit(1'b1); slave_bit(1'b0);
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd0, 8'h01);
        for (int i = 0; i < 8; i++) slave_bit(d_bit(8'h5A, i));
        wait_stat(0, seen);
        reg_rd(2'd2, d);
        check(seen && d == 8'h5A, "R10 partial byte discarded", d, 8'h5A);
        reg_wr(2'd0, 8'h00);
        use_slave = 1'b0;
    endtask

    function automatic logic d_bit(input logic [7:0] v, input int i);
        return v[i];
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) feed_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset;
        test_clock;
        test_continuous_stop;
        test_overrun;
        test_slave;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule